// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block sequences a processor core through its low-power states. On every rising edge of the bus clock it samples two active-low requests: a stop-clock request and a sleep request. From these it moves the core between Normal, Stop-Grant and Sleep. An active-low asynchronous reset forces the controller into a Reset state from any state, including Sleep, without passing back through Stop-Grant. The controller returns to Normal on the first clock edge after reset is released.

Each state drives a fixed set of enables: the core-clock enable, a keep-alive indicator for the clock-generating PLL, a snoop-accept flag and an interrupt-latch enable. The controller also checks the input protocol. A sleep request outside Stop-Grant is a violation. So is a sleep request released before it has been held for a minimum number of clocks. So is any change on the other bus inputs while the core sleeps or crosses into or out of Sleep. Every violation sets a sticky flag that only reset clears.

Top module: `lp_state_ctrl`

## Requirements
- R1: While `rst_n` is low, the controller is in Reset (`state_o` = 2'b11), `viol_o` is 0 and all four enables are 0. The first rising clock edge after `rst_n` rises moves the controller to Normal (2'b00).
- R2: In Normal, a low `stop_req_n` moves the controller to Stop-Grant (2'b01) on the next edge. In Stop-Grant, a high `stop_req_n` with `sleep_req_n` high moves it back to Normal.
- R3: Sleep (2'b10) is entered only from Stop-Grant. The entry happens on the edge at which `sleep_req_n` has been sampled low on MIN_SLP_CYC consecutive edges (default 2) in Stop-Grant.
- R4: A low `sleep_req_n` sampled in Normal or Reset sets `viol_o` on the next edge and does not change the state.
- R5: In Stop-Grant, if `sleep_req_n` is sampled high after at least one low sample but before the entry to Sleep, `viol_o` is set on the next edge.
- R6: In Sleep, a high `sleep_req_n` returns the controller to Stop-Grant on the next edge.
- R7: `core_clk_en` is 1 only in Normal. `snoop_ok` and `irq_latch_en` are 1 in Normal and Stop-Grant. `pll_keep` is 1 in every state except Reset.
- R8: `viol_o` is set on the next edge if `bus_evt` or `stop_req_n` differs from its previous sample in any of these cycles:
  - a cycle in Sleep;
  - the cycle of the edge that enters Sleep;
  - the first cycle after leaving Sleep.
- R9: Once set, `viol_o` stays 1 until `rst_n` is asserted.
- R10: Asserting `rst_n` while in Sleep moves the controller straight to Reset (2'b11).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| stop_req_n | input | 1 | Stop-clock request, active low |
| sleep_req_n | input | 1 | Sleep request, active low |
| bus_evt | input | EVT_W | Other bus inputs (snoop strobes, interrupt lines) that must stay still in Sleep |
| state_o | output | 2 | Current state: 00 Normal, 01 Stop-Grant, 10 Sleep, 11 Reset |
| core_clk_en | output | 1 | Enable for the core clock gates |
| pll_keep | output | 1 | Keep the PLL running |
| snoop_ok | output | 1 | Snoop requests may be accepted |
| irq_latch_en | output | 1 | Interrupt inputs may be latched |
| viol_o | output | 1 | Sticky protocol-violation flag |

## Verification
The transition assertions assume that the requests are synchronous to the bus clock and that reset is only released away from a clock edge. The bench meets both conditions by driving every input, `rst_n` included, on the falling edge.

The constrained random stimulus biases the sleep request according to the state the bench model predicts, so that Sleep is entered and left often. Changes on `bus_evt` are rare, and the bench pulses reset periodically so that the sticky flag does not hide later violations. Directed sequences cover the following cases:
- a misplaced sleep request;
- a sleep request that is too short;
- an input change while in Sleep;
- reset asserted while in Sleep.

// File: rtl/lp_pkg.sv
package lp_pkg;
   typedef enum logic [1:0] {
      ST_NORMAL = 2'b00,
      ST_STOPG  = 2'b01,
      ST_SLEEP  = 2'b10,
      ST_RESET  = 2'b11
   } lp_state_e;
endpackage

// File: rtl/lp_sleep_qual.sv
module lp_sleep_qual #(
   parameter int MIN_SLP_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_sg_i,
   input  logic sleep_i,
   output logic qualify_o,
   output logic short_o
);
   localparam int CNT_W = (MIN_SLP_CYC > 1) ? $clog2(MIN_SLP_CYC) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_SLP_CYC - 1);

   if (MIN_SLP_CYC < 1) begin : g_bad_min
      $error("MIN_SLP_CYC must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   assign qualify_o = in_sg_i & sleep_i & (cnt_q == LAST);
   assign short_o   = in_sg_i & ~sleep_i & (cnt_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             cnt_q <= '0;
      else if (in_sg_i & sleep_i & ~qualify_o) cnt_q <= cnt_q + 1'b1;
      else                                    cnt_q <= '0;
   end

   AST_QUAL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0) |-> $past(in_sg_i & sleep_i)); // R3
endmodule

// File: rtl/lp_fsm.sv
module lp_fsm
   import lp_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      stop_req_i,
   input  logic      sleep_req_i,
   input  logic      qualify_i,
   output lp_state_e state_o,
   output logic      going_sleep_o,
   output logic      left_sleep_o,
   output logic      misplaced_o
);
   lp_state_e state_q, state_d;
   logic      left_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_RESET:  state_d = ST_NORMAL;
         ST_NORMAL: if (stop_req_i) state_d = ST_STOPG;
         ST_STOPG: begin
            if (sleep_req_i) begin
               if (qualify_i) state_d = ST_SLEEP;
            end else if (!stop_req_i) begin
               state_d = ST_NORMAL;
            end
         end
         ST_SLEEP:  if (!sleep_req_i) state_d = ST_STOPG;
         default:   state_d = ST_RESET;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RESET;
         left_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         left_q  <= (state_q == ST_SLEEP) && (state_d != ST_SLEEP);
      end
   end

   assign state_o       = state_q;
   assign going_sleep_o = (state_q == ST_STOPG) && (state_d == ST_SLEEP);
   assign left_sleep_o  = left_q;
   assign misplaced_o   = sleep_req_i && (state_q == ST_NORMAL || state_q == ST_RESET);

   AST_SLEEP_FROM_SG: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SLEEP) |-> ($past(state_q) == ST_STOPG || $past(state_q) == ST_SLEEP)); // R3
   AST_SLEEP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SLEEP && !sleep_req_i) |=> (state_q == ST_STOPG)); // R6
   AST_NORMAL_TO_SG: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_NORMAL && stop_req_i) |=> (state_q == ST_STOPG)); // R2
   AST_MISPLACED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_NORMAL && sleep_req_i && !stop_req_i) |=> (state_q == ST_NORMAL)); // R4
endmodule

// File: rtl/lp_viol_mon.sv
module lp_viol_mon
   import lp_pkg::*;
#(
   parameter int EVT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  lp_state_e        state_i,
   input  logic             going_sleep_i,
   input  logic             left_sleep_i,
   input  logic             misplaced_i,
   input  logic             short_i,
   input  logic             stop_n_i,
   input  logic [EVT_W-1:0] evt_i,
   output logic             viol_o
);
   if (EVT_W < 1) begin : g_bad_w
      $error("EVT_W must be at least 1");
   end

   logic [EVT_W-1:0] evt_q;
   logic [EVT_W-1:0] evt_chg;
   logic             stop_q;
   logic             viol_q;
   logic             watch;
   logic             moved;

   for (genvar i = 0; i < EVT_W; i++) begin : g_chg
      assign evt_chg[i] = evt_i[i] ^ evt_q[i];
   end

   assign watch = (state_i == ST_SLEEP) | going_sleep_i | left_sleep_i;
   assign moved = (|evt_chg) | (stop_n_i ^ stop_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_q  <= '0;
         stop_q <= 1'b1;
         viol_q <= 1'b0;
      end else begin
         evt_q  <= evt_i;
         stop_q <= stop_n_i;
         viol_q <= viol_q | misplaced_i | short_i | (watch & moved);
      end
   end

   assign viol_o = viol_q;

   AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      viol_q |=> viol_q); // R9
   AST_MISPLACED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      misplaced_i |=> viol_q); // R4
   AST_SHORT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      short_i |=> viol_q); // R5
   AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i == ST_SLEEP && !$stable(evt_i)) |=> viol_q); // R8
endmodule

// File: rtl/lp_state_ctrl.sv
module lp_state_ctrl
   import lp_pkg::*;
#(
   parameter int EVT_W       = 4,
   parameter int MIN_SLP_CYC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stop_req_n,
   input  logic             sleep_req_n,
   input  logic [EVT_W-1:0] bus_evt,
   output logic [1:0]       state_o,
   output logic             core_clk_en,
   output logic             pll_keep,
   output logic             snoop_ok,
   output logic             irq_latch_en,
   output logic             viol_o
);
   lp_state_e state;
   logic      qualify, short_pulse, going_sleep, left_sleep, misplaced;

   lp_sleep_qual #(.MIN_SLP_CYC(MIN_SLP_CYC)) u_qual (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_sg_i   (state == ST_STOPG),
      .sleep_i   (~sleep_req_n),
      .qualify_o (qualify),
      .short_o   (short_pulse)
   );

   lp_fsm u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .stop_req_i    (~stop_req_n),
      .sleep_req_i   (~sleep_req_n),
      .qualify_i     (qualify),
      .state_o       (state),
      .going_sleep_o (going_sleep),
      .left_sleep_o  (left_sleep),
      .misplaced_o   (misplaced)
   );

   lp_viol_mon #(.EVT_W(EVT_W)) u_viol (
      .clk           (clk),
      .rst_n         (rst_n),
      .state_i       (state),
      .going_sleep_i (going_sleep),
      .left_sleep_i  (left_sleep),
      .misplaced_i   (misplaced),
      .short_i       (short_pulse),
      .stop_n_i      (stop_req_n),
      .evt_i         (bus_evt),
      .viol_o        (viol_o)
   );

   assign state_o      = state;
   assign core_clk_en  = (state == ST_NORMAL);
   assign snoop_ok     = (state == ST_NORMAL) || (state == ST_STOPG);
   assign irq_latch_en = snoop_ok;
   assign pll_keep     = (state != ST_RESET);

   AST_CORE_IMPLIES_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
      core_clk_en |-> (snoop_ok && irq_latch_en && pll_keep)); // R7
   AST_SLEEP_NO_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'b10) |-> (!snoop_ok && !irq_latch_en && pll_keep)); // R7
endmodule

// File: tb/lp_state_ctrl_bench.sv
`timescale 1ns/1ps
module lp_state_ctrl_bench;
   localparam int EVT_W = 4;
   localparam int MIN   = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic stop_n = 1'b1, sleep_n = 1'b1;
   logic [EVT_W-1:0] evt = '0;
   logic [1:0] state_o;
   logic core_clk_en, pll_keep, snoop_ok, irq_latch_en, viol_o;

   int n_chk = 0, n_bad = 0;

   always #10 clk = ~clk;

   lp_state_ctrl #(.EVT_W(EVT_W), .MIN_SLP_CYC(MIN)) u_lp_state_ctrl (
      .clk(clk), .rst_n(rst_n), .stop_req_n(stop_n), .sleep_req_n(sleep_n),
      .bus_evt(evt), .state_o(state_o), .core_clk_en(core_clk_en),
      .pll_keep(pll_keep), .snoop_ok(snoop_ok), .irq_latch_en(irq_latch_en),
      .viol_o(viol_o));

   // reference model built from the requirements
   logic [1:0] m_st;
   int         m_cnt;
   logic       m_viol, m_stq, m_left;
   logic [EVT_W-1:0] m_evq;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 2'b11; m_cnt = 0; m_viol = 0; m_evq = '0; m_stq = 1; m_left = 0;
      end else begin
         logic s, p, go, v, watch;
         logic [1:0] nx;
         s = ~sleep_n; p = ~stop_n;
         go = (m_st == 2'b01) && s && (m_cnt == MIN - 1);
         v = 0;
         if (s && (m_st == 2'b00 || m_st == 2'b11)) v = 1;
         if (m_st == 2'b01 && !s && m_cnt != 0) v = 1;
         watch = (m_st == 2'b10) || go || m_left;
         if (watch && (evt != m_evq || stop_n != m_stq)) v = 1;
         case (m_st)
            2'b11: nx = 2'b00;
            2'b00: nx = p ? 2'b01 : 2'b00;
            2'b01: nx = s ? (go ? 2'b10 : 2'b01) : (p ? 2'b01 : 2'b00);
            default: nx = s ? 2'b10 : 2'b01;
         endcase
         m_cnt  = (m_st == 2'b01 && s && !go) ? m_cnt + 1 : 0;
         m_left = (m_st == 2'b10) && (nx != 2'b10);
         m_evq  = evt;
         m_stq  = stop_n;
         m_viol = m_viol | v;
         m_st   = nx;
      end
   end

   function automatic logic [3:0] exp_out(input logic [1:0] st);
      // {core, pll, snoop, irq}
      return {st == 2'b00, st != 2'b11, st == 2'b00 || st == 2'b01, st == 2'b00 || st == 2'b01};
   endfunction

   task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_all(input string ts, input string to, input string tv);
      chk(ts, {2'b00, state_o}, {2'b00, m_st});
      chk(to, {core_clk_en, pll_keep, snoop_ok, irq_latch_en}, exp_out(m_st));
      chk(tv, {3'b000, viol_o}, {3'b000, m_viol});
   endtask

   // at a falling edge: drive, clock once, check at next falling edge
   task automatic step(input logic sn, input logic sl, input logic [EVT_W-1:0] ev,
                       input string ts, input string to, input string tv);
      stop_n = sn; sleep_n = sl; evt = ev;
      @(posedge clk);
      @(negedge clk);
      check_all(ts, to, tv);
   endtask

   task automatic do_reset(input string tag);
      rst_n = 1'b0;
      #1;
      check_all(tag, "R1", "R1");
      chk("R1 reset state", {2'b00, state_o}, 4'b0011);
      stop_n = 1; sleep_n = 1;
      @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      step(1, 1, evt, "R1", "R7", "R1");
      chk("R1 leave reset", {2'b00, state_o}, 4'b0000);
   endtask

   initial begin
      void'($urandom(32'h5eed_1234));
      @(negedge clk);
      do_reset("R1");
      // R2: Normal <-> Stop-Grant
      step(0, 1, 4'h0, "R2", "R7", "R9");
      chk("R2 to stop-grant", {2'b00, state_o}, 4'b0001);
      step(1, 1, 4'h0, "R2", "R7", "R9");
      chk("R2 back to normal", {2'b00, state_o}, 4'b0000);
      // R4: misplaced sleep request in Normal
      step(1, 0, 4'h0, "R4", "R7", "R4");
      chk("R4 state held", {2'b00, state_o}, 4'b0000);
      chk("R4 flag", {3'b000, viol_o}, 4'b0001);
      step(1, 1, 4'h0, "R9", "R7", "R9");
      chk("R9 sticky", {3'b000, viol_o}, 4'b0001);
      do_reset("R9");
      chk("R9 cleared", {3'b000, viol_o}, 4'b0000);
      // R5: too-short sleep request
      step(0, 1, 4'h0, "R2", "R7", "R9");
      step(0, 0, 4'h0, "R5", "R7", "R5");
      step(0, 1, 4'h0, "R5", "R7", "R5");
      chk("R5 short pulse", {3'b000, viol_o}, 4'b0001);
      do_reset("R1");
      // R3/R6: proper sleep entry and exit
      step(0, 1, 4'h3, "R2", "R7", "R9");
      step(0, 0, 4'h3, "R3", "R7", "R3");
      chk("R3 not yet", {2'b00, state_o}, 4'b0001);
      step(0, 0, 4'h3, "R3", "R7", "R3");
      chk("R3 sleep", {2'b00, state_o}, 4'b0010);
      chk("R7 sleep outputs", {core_clk_en, pll_keep, snoop_ok, irq_latch_en}, 4'b0100);
      step(0, 0, 4'h3, "R3", "R7", "R8");
      step(0, 1, 4'h3, "R6", "R7", "R8");
      chk("R6 exit", {2'b00, state_o}, 4'b0001);
      chk("R8 clean run", {3'b000, viol_o}, 4'b0000);
      // R8 and R10: activity in Sleep, then reset from Sleep
      step(0, 0, 4'h3, "R3", "R7", "R8");
      step(0, 0, 4'h3, "R3", "R7", "R8");
      step(0, 0, 4'h7, "R8", "R7", "R8");
      chk("R8 sleep activity", {3'b000, viol_o}, 4'b0001);
      rst_n = 1'b0;
      #1;
      chk("R10 reset from sleep", {2'b00, state_o}, 4'b0011);
      do_reset("R10");
      // constrained random
      for (int i = 0; i < 3000; i++) begin
         logic sn, sl;
         logic [EVT_W-1:0] ev;
         sn = ($urandom_range(99) < 40);
         if (m_st == 2'b01 || m_st == 2'b10) sl = ($urandom_range(99) >= 70);
         else                                sl = ($urandom_range(99) >= 3);
         if (m_st == 2'b10) sn = stop_n;
         ev = evt;
         if ($urandom_range(99) < 3) ev = EVT_W'($urandom);
         step(sn, sl, ev, "R3", "R7", "R8");
         if ((i % 200) == 199 || (m_viol && $urandom_range(99) < 10)) do_reset("R1");
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(20 * 150000);
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule